// File: doc/BRIEF.md
# Watchdog Timer with Shared Identification Port

This block is a watchdog timer for a single-board computer. It sits on a plain 8-bit host I/O bus made of an address, write data, a read strobe and a write strobe. One port address serves two registers with opposite directions. A read at that address returns a fixed board identification byte. A write at that address is a kick register that accepts only one key value. Writing the key restarts the countdown, and any other value is ignored.

The watchdog counts only while an enable input is high. This input and two action-select inputs come from a control register outside the block. When the countdown runs out, the block can do either or both of two things:
- drive a CPU reset pulse of fixed length;
- raise a non-maskable interrupt request, which stays high until the next kick or until the watchdog is disabled.

The timeout is a prescaler followed by a tick counter. Both are derived from the clock frequency, which is a parameter. In the product setting the period is at least one second. A relocation input moves the port from 0x0E1 to 0x1E1.

Top module: `wdog_idport`

## Requirements
- R1: A read strobe at the selected address drives `io_rdata` with the identification byte. Bits 7:3 are the product code (default 00001). Bit 2 is the throttling code (0 means no throttling, 1 means throttling at 37.5%). Bits 1:0 are the revision level (00 is the first release). With no read strobe, or at any other address, `io_rdata` is 0x00.
- R2: The selected address is 0x0E1 when `alt_base` is 0 and 0x1E1 when `alt_base` is 1. Any other address neither reads nor kicks.
- R3: A write of 0x5A at the selected address restarts the count. Expiry then happens at the clock edge that comes PRESCALE*TIMEOUT_TICKS edges after the kick edge, provided no further kick arrives.
- R4: A write of any other byte, or a write of 0x5A at an address that is not selected, leaves the count unchanged.
- R5: No write, whatever its value, changes the byte returned by later reads.
- R6: The count advances only while `wd_enable` is 1. While it is 0 the count is held at its start value and `nmi_o` is cleared.
- R7: On expiry with `act_reset` = 1, `cpu_reset_o` goes high from the next cycle for exactly RST_LEN cycles.
- R8: On expiry with `act_nmi` = 1, `nmi_o` goes high from the next cycle. It stays high until a valid kick or until `wd_enable` goes low.
- R9: A valid kick in the cycle that would otherwise expire wins. No expiry happens and the count restarts.
- R10: While reset is active, and for two clock edges after it is released, both outputs are low and the count is at its start value.
- R11: After an expiry the count restarts by itself, so an unserviced watchdog expires again once every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 10 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data, the identification byte when selected, otherwise zero |
| alt_base | input | 1 | Port relocation: 0 selects 0x0E1, 1 selects 0x1E1 |
| wd_enable | input | 1 | Watchdog run enable from the external control register |
| act_reset | input | 1 | Expiry drives a CPU reset pulse |
| act_nmi | input | 1 | Expiry raises the NMI request |
| cpu_reset_o | output | 1 | CPU reset pulse |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
A kick and an expiry can fall in the same clock cycle. When they do, the kick must suppress the expiry, so no reset pulse starts and the NMI request stays low. The bench provokes this by kicking once and then kicking again exactly one period later. The edge of the second kick is the edge on which the count would otherwise run out. A per-cycle reference model in the bench judges the outcome by comparing both outputs on every cycle that follows. The bench also kicks one cycle early and one cycle late, so that an off-by-one error in the comparison shows up as a mismatch.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [9:0] PORT_PRI = 10'h0E1;
  localparam logic [9:0] PORT_ALT = 10'h1E1;
  localparam logic [7:0] KICK_KEY = 8'h5A;
  localparam int         ADDR_W   = 10;
  localparam int         DATA_W   = 8;
endpackage

// File: rtl/wdog_rstsync.sv
module wdog_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/wdog_busif.sv
module wdog_busif
  import wdog_pkg::*;
#(
  parameter logic [4:0] PRODUCT_CODE = 5'b00001,
  parameter logic       THROTTLE     = 1'b0,
  parameter logic [1:0] REVISION     = 2'b00
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              alt_base,
  output logic [DATA_W-1:0] io_rdata,
  output logic              kick
);
  localparam logic [DATA_W-1:0] ID_BYTE = {PRODUCT_CODE, THROTTLE, REVISION};

  logic [ADDR_W-1:0] base;
  logic              sel;

  always_comb begin
    base     = alt_base ? PORT_ALT : PORT_PRI;
    sel      = (io_addr == base);
    io_rdata = (io_rd && sel) ? ID_BYTE : '0;
    kick     = io_wr && sel && (io_wdata == KICK_KEY);
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int PRESCALE = 125000,
  parameter int TICKS    = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic kick,
  output logic expire
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRESCALE - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] tick_q, tick_d;
  logic          pre_wrap, tick_last;

  always_comb begin
    pre_wrap  = (pre_q == PRE_LAST);
    tick_last = (tick_q == TICK_LAST);
    expire    = en && !kick && pre_wrap && tick_last;
    pre_d     = pre_q;
    tick_d    = tick_q;
    if (!en || kick) begin
      pre_d  = '0;
      tick_d = '0;
    end else if (pre_wrap) begin
      pre_d  = '0;
      tick_d = tick_last ? '0 : tick_q + 1'b1;
    end else begin
      pre_d  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q  <= pre_d;
      tick_q <= tick_d;
    end
  end

  AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (pre_q == '0 && tick_q == '0)); // R3
  AST_HOLD_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_q == '0 && tick_q == '0)); // R6
  AST_REARM_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (pre_q == '0 && tick_q == '0)); // R11
endmodule

// File: rtl/wdog_outgen.sv
module wdog_outgen #(
  parameter int RST_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic kick,
  input  logic expire,
  input  logic act_reset,
  input  logic act_nmi,
  output logic cpu_reset_o,
  output logic nmi_o
);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [RW-1:0] RST_LOAD = RW'(RST_LEN);

  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          nmi_q, nmi_d;
  logic          rcnt_ce;

  always_comb begin
    rcnt_ce = (expire && act_reset) || (rcnt_q != '0);
    rcnt_d  = (expire && act_reset) ? RST_LOAD : rcnt_q - 1'b1;
    nmi_d   = nmi_q;
    if (!en || kick)            nmi_d = 1'b0;
    else if (expire && act_nmi) nmi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      if (rcnt_ce) rcnt_q <= rcnt_d;
      nmi_q <= nmi_d;
    end
  end

  assign cpu_reset_o = (rcnt_q != '0);
  assign nmi_o       = nmi_q;

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && act_reset) |=> cpu_reset_o); // R7
  AST_NMI_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && act_nmi) |=> nmi_o); // R8
  AST_NMI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick || !en) |=> !nmi_o); // R6
endmodule

// File: rtl/wdog_idport.sv
module wdog_idport
  import wdog_pkg::*;
#(
  parameter int         CLK_HZ        = 125_000_000,
  parameter int         TICK_HZ       = 1000,
  parameter int         TIMEOUT_TICKS = 1000,
  parameter int         RST_LEN       = 64,
  parameter logic [4:0] PRODUCT_CODE  = 5'b00001,
  parameter logic       THROTTLE      = 1'b0,
  parameter logic [1:0] REVISION      = 2'b00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [DATA_W-1:0]   io_wdata,
  input  logic                io_rd,
  input  logic                io_wr,
  output logic [DATA_W-1:0]   io_rdata,
  input  logic                alt_base,
  input  logic                wd_enable,
  input  logic                act_reset,
  input  logic                act_nmi,
  output logic                cpu_reset_o,
  output logic                nmi_o
);
  localparam int PRESCALE = CLK_HZ / TICK_HZ;

  logic rst_int_n;
  logic kick;
  logic expire;

  wdog_rstsync u_rstsync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  wdog_busif #(
    .PRODUCT_CODE (PRODUCT_CODE),
    .THROTTLE     (THROTTLE),
    .REVISION     (REVISION)
  ) u_busif (
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .alt_base (alt_base),
    .io_rdata (io_rdata),
    .kick     (kick)
  );

  wdog_timer #(
    .PRESCALE (PRESCALE),
    .TICKS    (TIMEOUT_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (wd_enable),
    .kick   (kick),
    .expire (expire)
  );

  wdog_outgen #(
    .RST_LEN (RST_LEN)
  ) u_outgen (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en          (wd_enable),
    .kick        (kick),
    .expire      (expire),
    .act_reset   (act_reset),
    .act_nmi     (act_nmi),
    .cpu_reset_o (cpu_reset_o),
    .nmi_o       (nmi_o)
  );

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !io_rd |-> (io_rdata == '0)); // R1
  AST_ID_CONSTANT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_rd && io_rdata != '0) |-> (io_rdata == {PRODUCT_CODE, THROTTLE, REVISION})); // R5
  AST_NO_EXPIRY_ON_KICK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (kick && !cpu_reset_o) |=> !cpu_reset_o); // R9
endmodule

// File: tb/wdog_idport_bench.sv
`timescale 1ns/1ps
module wdog_idport_bench;
  localparam int PER  = 20;
  localparam int RLEN = 3;
  localparam logic [7:0] ID = 8'b00001_0_00;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_rdata;
  logic       alt_base = 1'b0, wd_enable = 1'b0, act_reset = 1'b0, act_nmi = 1'b0;
  logic       cpu_reset_o, nmi_o;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  wdog_idport #(
    .CLK_HZ (16), .TICK_HZ (4), .TIMEOUT_TICKS (5), .RST_LEN (RLEN)
  ) u_wdog_idport (
    .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wdata (io_wdata),
    .io_rd (io_rd), .io_wr (io_wr), .io_rdata (io_rdata), .alt_base (alt_base),
    .wd_enable (wd_enable), .act_reset (act_reset), .act_nmi (act_nmi),
    .cpu_reset_o (cpu_reset_o), .nmi_o (nmi_o)
  );

  // behavioural reference model
  int  m_sync, m_elapsed, m_rcnt;
  bit  m_nmi;

  function automatic bit m_hit();
    return io_addr == (alt_base ? 10'h1E1 : 10'h0E1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_elapsed = 0; m_rcnt = 0; m_nmi = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit kick, fire;
      kick = io_wr && m_hit() && io_wdata == 8'h5A;
      fire = 0;
      if (!wd_enable || kick) m_elapsed = 0;
      else if (m_elapsed == PER - 1) begin fire = 1; m_elapsed = 0; end
      else m_elapsed++;
      if (!wd_enable || kick) m_nmi = 0;
      else if (fire && act_nmi) m_nmi = 1;
      if (fire && act_reset) m_rcnt = RLEN;
      else if (m_rcnt > 0) m_rcnt--;
    end
  end

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    check("R1/R2/R5 io_rdata", io_rdata, (io_rd && m_hit()) ? ID : 8'h00);
    check("R7/R3/R4/R11 cpu_reset_o", cpu_reset_o, m_rcnt > 0);
    check("R8/R6/R9 nmi_o", nmi_o, m_nmi);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      io_rd = 0; io_wr = 0; io_addr = '0; io_wdata = '0;
    end
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1; io_rd = 0;
    @(posedge clk); #1;
    io_wr = 0; io_addr = '0; io_wdata = '0;
  endtask

  task automatic rd(logic [9:0] a);
    @(posedge clk); #1;
    io_addr = a; io_rd = 1; io_wr = 0;
    @(posedge clk); #1;
    io_rd = 0; io_addr = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    // R10: outputs low during and just after reset
    #3;
    check("R10 reset nmi", nmi_o, 0);
    check("R10 reset cpu_reset", cpu_reset_o, 0);
    idle(3);
    rst_n = 1;
    idle(4);
    // R1 R2: identification read and port relocation
    rd(10'h0E1); rd(10'h1E1); rd(10'h0E2);
    alt_base = 1;
    rd(10'h1E1); rd(10'h0E1);
    alt_base = 0;
    // R7 R8: expiry with both actions
    wd_enable = 1; act_reset = 1; act_nmi = 1;
    idle(PER + 6);
    // R8: a kick clears the held NMI request
    wr(10'h0E1, 8'h5A);
    // R3: periodic kicks keep the watchdog quiet
    repeat (4) begin wr(10'h0E1, 8'h5A); idle(PER - 6); end
    // R4: wrong values and a wrong address do not restart the count
    wr(10'h0E1, 8'h5A); idle(5);
    wr(10'h0E1, 8'h5B); wr(10'h0E1, 8'h00); wr(10'h1E1, 8'h5A);
    idle(PER);
    // R5: writes leave the readback unchanged
    wr(10'h0E1, 8'hFF); rd(10'h0E1); wr(10'h0E1, 8'h00); rd(10'h0E1);
    // R9: kick landing on the expiry edge, then one edge early and one late
    wr(10'h0E1, 8'h5A); idle(PER - 2); wr(10'h0E1, 8'h5A);
    idle(PER - 3); wr(10'h0E1, 8'h5A);
    idle(PER - 1); wr(10'h0E1, 8'h5A);
    // relocated kick
    alt_base = 1;
    wr(10'h1E1, 8'h5A); idle(PER - 2); wr(10'h1E1, 8'h5A);
    alt_base = 0;
    // R6: disable while NMI is held, then hold off
    act_reset = 0;
    idle(PER + 4);
    wd_enable = 0;
    idle(PER * 2);
    // R11: reset action only, unserviced: repeated pulses
    wd_enable = 1; act_reset = 1; act_nmi = 0;
    idle(PER * 3 + 5);
    wd_enable = 0;
    idle(5);
    // R10: reset asserted mid-run
    wd_enable = 1; act_nmi = 1;
    idle(PER + 2);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(PER + 8);
    finish_run();
  end
endmodule